// File: doc/BRIEF.md
# Wormhole Virtual-Channel Mesh Router

This block is one node of a two-dimensional mesh network-on-chip. It has five ports: north, south, east, west and local. Each port has one 38-bit link word in each direction. Flits that arrive on a port are written into one of two per-port virtual-channel buffers, each eight flits deep. A head flit carries its destination coordinates in its low payload bits. The router routes it in dimension order, correcting X first and then Y, and ejects it to the local port when both coordinates match. The head reserves an output virtual channel on the chosen port. Body and tail flits follow on that channel, and the tail frees it.

Each output port picks one flit per step with a round-robin arbiter over all ten input virtual channels. A flit is sent only when its output virtual channel holds a credit. Each flit taken from a buffer returns one credit bit to the upstream neighbour. The router is meant for cycle-accurate emulation. All of its state moves only in cycles where the emulation enable is high, so a mesh of these routers steps together, one enabled cycle for each emulated cycle.

Top module: `mesh_vc_router`

## Requirements
- R1: After reset, every outgoing link word has its valid bit (bit 32) and both credit-return bits (bits 37:36) at zero.
- R2: The link word is laid out as payload at bits 31:0, valid at bit 32, flit kind at bits 34:33 (0 head, 1 body, 2 tail, 3 single), virtual channel at bit 35, and credit return for VC0 and VC1 at bits 36 and 37.
- R3: A head or single flit with destination X at payload bits 2:0 and Y at bits 5:3 leaves the router on the port chosen as follows. If X is greater than the router's X it goes east; if X is smaller it goes west. If X matches, it goes north when Y is greater, south when Y is smaller, and local when Y also matches.
- R4: A head flit reserves a free output VC on its port. Body and tail flits of that packet leave on the same port and VC in order. Another head cannot take a reserved VC until the tail has been sent.
- R5: Each output VC has a credit counter that starts at 8. Each flit sent on the VC takes one credit, and each credit bit received on that port's incoming link returns one. No flit is sent on a VC with zero credits.
- R6: In the step where a flit leaves an input VC buffer, the outgoing link of that same port sets the credit bit for that VC.
- R7: When several input VCs compete for one output port, the grants rotate round-robin. Two inputs that keep requesting are served alternately.
- R8: While the emulation enable is low, incoming link words are ignored and the outgoing link words hold their values.
- R9: An uncontested flit that is sampled on enabled step k is visible on its output link after enabled step k+1, and not earlier.
- R10: Each input VC buffers up to 8 flits without loss, and they leave in arrival order once credits allow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| emu_en_i | input | 1 | Emulation step enable; state advances only when high |
| pos_x_i | input | 3 | X coordinate of this router |
| pos_y_i | input | 3 | Y coordinate of this router |
| link_i | input | 190 | Incoming link words, port p at bits [p*38 +: 38] (0 north, 1 south, 2 east, 3 west, 4 local) |
| link_o | output | 190 | Outgoing link words, same port order and layout |

## Verification
A flit driven before enabled edge k is in its buffer after that edge. It appears on the output link, together with the matching upstream credit bit, after edge k+1. A returned credit likewise unblocks a waiting flit one edge after it is sampled. The bench drives inputs at the falling edge, steps one rising edge at a time, and samples each output at the falling edge after the edge on which that result is due. It also checks the output one edge earlier where early arrival would be a fault. With the enable low, the bench counts edges and checks that nothing moves. The first output is then expected exactly one enabled edge after the enable rises again.

// File: rtl/noc_router_pkg.sv
package noc_router_pkg;
  typedef enum logic [1:0] {
    FT_HEAD   = 2'd0,
    FT_BODY   = 2'd1,
    FT_TAIL   = 2'd2,
    FT_SINGLE = 2'd3
  } flit_kind_e;

  localparam int NUM_PORTS = 5;
  localparam logic [2:0] P_NORTH = 3'd0;
  localparam logic [2:0] P_SOUTH = 3'd1;
  localparam logic [2:0] P_EAST  = 3'd2;
  localparam logic [2:0] P_WEST  = 3'd3;
  localparam logic [2:0] P_LOCAL = 3'd4;
endpackage

// File: rtl/router_vc_fifo.sv
module router_vc_fifo #(
  parameter int W     = 34,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop, full;

  assign do_push = en_i && push_i;
  assign do_pop  = en_i && pop_i && !empty_o;
  assign empty_o = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign data_o  = mem[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_q] <= data_i;
  end

  // upstream must respect credits: no write into a full buffer
  assert_no_overflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_push && full) |-> do_pop);
endmodule

// File: rtl/router_xy_route.sv
module router_xy_route
  import noc_router_pkg::*;
#(
  parameter int COORD_W = 3
) (
  input  logic [COORD_W-1:0] here_x_i,
  input  logic [COORD_W-1:0] here_y_i,
  input  logic [COORD_W-1:0] dst_x_i,
  input  logic [COORD_W-1:0] dst_y_i,
  output logic [2:0]         port_o
);
  always_comb begin
    if      (dst_x_i > here_x_i) port_o = P_EAST;
    else if (dst_x_i < here_x_i) port_o = P_WEST;
    else if (dst_y_i > here_y_i) port_o = P_NORTH;
    else if (dst_y_i < here_y_i) port_o = P_SOUTH;
    else                         port_o = P_LOCAL;
  end
endmodule

// File: rtl/router_rr_arb.sv
module router_rr_arb #(
  parameter int N = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr_q, gidx;
  logic          found;

  always_comb begin
    int j;
    gnt_o = '0;
    gidx  = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      j = (int'(ptr_q) + i) % N;
      if (!found && req_i[j]) begin
        found    = 1'b1;
        gnt_o[j] = 1'b1;
        gidx     = IW'(j);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            ptr_q <= '0;
    else if (en_i && found) ptr_q <= (gidx == IW'(N - 1)) ? '0 : gidx + 1'b1;
  end

  assert_grant_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  assert_grant_has_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_o & ~req_i) == '0));
endmodule

// File: rtl/mesh_vc_router.sv
module mesh_vc_router
  import noc_router_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int COORD_W = 3,
  parameter int NUM_VC  = 2,
  parameter int DEPTH   = 8,
  localparam int VC_W   = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int LINK_W = DATA_W + 3 + VC_W + NUM_VC
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          emu_en_i,
  input  logic [COORD_W-1:0]            pos_x_i,
  input  logic [COORD_W-1:0]            pos_y_i,
  input  logic [NUM_PORTS*LINK_W-1:0]   link_i,
  output logic [NUM_PORTS*LINK_W-1:0]   link_o
);
  localparam int NUM_IVC = NUM_PORTS * NUM_VC;
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int FW      = DATA_W + 2;

  // incoming link fields
  logic              in_valid [NUM_PORTS];
  logic [VC_W-1:0]   in_vc    [NUM_PORTS];
  logic [NUM_VC-1:0] cred_in  [NUM_PORTS];
  logic [FW-1:0]     in_flit  [NUM_PORTS];

  // per input VC
  logic [FW-1:0]     fifo_dout [NUM_IVC];
  logic              fifo_empty[NUM_IVC];
  logic [2:0]        head_port [NUM_IVC];
  flit_kind_e        front_kind[NUM_IVC];
  logic              ivc_alloc [NUM_IVC];
  logic [2:0]        ivc_port  [NUM_IVC];
  logic [VC_W-1:0]   ivc_ovc   [NUM_IVC];
  logic [2:0]        want_port [NUM_IVC];
  logic [VC_W-1:0]   want_ovc  [NUM_IVC];
  logic [NUM_IVC-1:0] req_ok, popped;

  // per output port / VC
  logic [CNT_W-1:0]   ovc_cred [NUM_PORTS][NUM_VC];
  logic [NUM_VC-1:0]  ovc_busy [NUM_PORTS];
  logic [NUM_IVC-1:0] arb_req  [NUM_PORTS];
  logic [NUM_IVC-1:0] arb_gnt  [NUM_PORTS];
  logic               send_v   [NUM_PORTS];
  logic [DATA_W-1:0]  send_data[NUM_PORTS];
  flit_kind_e         send_kind[NUM_PORTS];
  logic [VC_W-1:0]    send_vc  [NUM_PORTS];
  logic [NUM_VC-1:0]  sent_ovc [NUM_PORTS];

  // registered outgoing link words
  logic               out_v_q   [NUM_PORTS];
  logic [DATA_W-1:0]  out_data_q[NUM_PORTS];
  flit_kind_e         out_kind_q[NUM_PORTS];
  logic [VC_W-1:0]    out_vc_q  [NUM_PORTS];
  logic [NUM_VC-1:0]  cr_out_q  [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [LINK_W-1:0] w;
    assign w           = link_i[p*LINK_W +: LINK_W];
    assign in_valid[p] = w[DATA_W];
    assign in_flit[p]  = {w[DATA_W+2:DATA_W+1], w[DATA_W-1:0]};
    assign in_vc[p]    = w[DATA_W+3 +: VC_W];
    assign cred_in[p]  = w[DATA_W+3+VC_W +: NUM_VC];
    assign link_o[p*LINK_W +: LINK_W] =
      {cr_out_q[p], out_vc_q[p], out_kind_q[p], out_v_q[p], out_data_q[p]};

    for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
      localparam int IV = p * NUM_VC + v;
      router_vc_fifo #(.W(FW), .DEPTH(DEPTH)) u_fifo (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (emu_en_i),
        .push_i  (in_valid[p] && (in_vc[p] == VC_W'(v))),
        .data_i  (in_flit[p]),
        .pop_i   (popped[IV]),
        .data_o  (fifo_dout[IV]),
        .empty_o (fifo_empty[IV])
      );
      router_xy_route #(.COORD_W(COORD_W)) u_route (
        .here_x_i (pos_x_i),
        .here_y_i (pos_y_i),
        .dst_x_i  (fifo_dout[IV][COORD_W-1:0]),
        .dst_y_i  (fifo_dout[IV][2*COORD_W-1:COORD_W]),
        .port_o   (head_port[IV])
      );
      assign front_kind[IV] = flit_kind_e'(fifo_dout[IV][DATA_W+1:DATA_W]);

      assert_send_needs_credit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (emu_en_i && sent_ovc[p][v]) |-> (ovc_cred[p][v] != '0));
      assert_credit_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovc_cred[p][v] <= CNT_W'(DEPTH));
      assert_head_takes_free_vc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (emu_en_i && sent_ovc[p][v] && (send_kind[p] == FT_HEAD || send_kind[p] == FT_SINGLE))
          |-> !ovc_busy[p][v]);
    end

    router_rr_arb #(.N(NUM_IVC)) u_arb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (emu_en_i),
      .req_i  (arb_req[p]),
      .gnt_o  (arb_gnt[p])
    );
  end

  // request: allocated VCs follow their path, heads pick lowest free output VC with credit
  always_comb begin
    for (int iv = 0; iv < NUM_IVC; iv++) begin
      want_port[iv] = ivc_port[iv];
      want_ovc[iv]  = ivc_ovc[iv];
      req_ok[iv]    = 1'b0;
      if (!fifo_empty[iv]) begin
        if (ivc_alloc[iv]) begin
          req_ok[iv] = (ovc_cred[ivc_port[iv]][ivc_ovc[iv]] != '0);
        end else if (front_kind[iv] == FT_HEAD || front_kind[iv] == FT_SINGLE) begin
          want_port[iv] = head_port[iv];
          for (int v = NUM_VC - 1; v >= 0; v--) begin
            if (!ovc_busy[head_port[iv]][v] && ovc_cred[head_port[iv]][v] != '0) begin
              want_ovc[iv] = VC_W'(v);
              req_ok[iv]   = 1'b1;
            end
          end
        end
      end
    end
    for (int p = 0; p < NUM_PORTS; p++)
      for (int iv = 0; iv < NUM_IVC; iv++)
        arb_req[p][iv] = req_ok[iv] && (want_port[iv] == 3'(p));
  end

  always_comb begin
    popped = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      popped       = popped | arb_gnt[p];
      send_v[p]    = |arb_gnt[p];
      send_data[p] = '0;
      send_kind[p] = FT_BODY;
      send_vc[p]   = '0;
      for (int iv = 0; iv < NUM_IVC; iv++) begin
        if (arb_gnt[p][iv]) begin
          send_data[p] = fifo_dout[iv][DATA_W-1:0];
          send_kind[p] = front_kind[iv];
          send_vc[p]   = want_ovc[iv];
        end
      end
      for (int v = 0; v < NUM_VC; v++)
        sent_ovc[p][v] = send_v[p] && (send_vc[p] == VC_W'(v));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int iv = 0; iv < NUM_IVC; iv++) begin
        ivc_alloc[iv] <= 1'b0;
        ivc_port[iv]  <= '0;
        ivc_ovc[iv]   <= '0;
      end
    end else if (emu_en_i) begin
      for (int iv = 0; iv < NUM_IVC; iv++) begin
        if (popped[iv]) begin
          if (front_kind[iv] == FT_HEAD) begin
            ivc_alloc[iv] <= 1'b1;
            ivc_port[iv]  <= want_port[iv];
            ivc_ovc[iv]   <= want_ovc[iv];
          end else if (front_kind[iv] == FT_TAIL) begin
            ivc_alloc[iv] <= 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        ovc_busy[p]   <= '0;
        out_v_q[p]    <= 1'b0;
        out_data_q[p] <= '0;
        out_kind_q[p] <= FT_HEAD;
        out_vc_q[p]   <= '0;
        cr_out_q[p]   <= '0;
        for (int v = 0; v < NUM_VC; v++) ovc_cred[p][v] <= CNT_W'(DEPTH);
      end
    end else if (emu_en_i) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        out_v_q[p]    <= send_v[p];
        out_data_q[p] <= send_data[p];
        out_kind_q[p] <= send_kind[p];
        out_vc_q[p]   <= send_vc[p];
        cr_out_q[p]   <= popped[p*NUM_VC +: NUM_VC];
        for (int v = 0; v < NUM_VC; v++) begin
          ovc_cred[p][v] <= ovc_cred[p][v] + CNT_W'(cred_in[p][v]) - CNT_W'(sent_ovc[p][v]);
          if (sent_ovc[p][v] && send_kind[p] == FT_HEAD)      ovc_busy[p][v] <= 1'b1;
          else if (sent_ovc[p][v] && send_kind[p] == FT_TAIL) ovc_busy[p][v] <= 1'b0;
        end
      end
    end
  end

  assert_frozen_when_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !emu_en_i |=> $stable(link_o));
endmodule

// File: tb/mesh_vc_router_tb.sv
`timescale 1ns/1ps
module mesh_vc_router_tb;
  localparam int LW = 38;
  localparam int PN = 0, PS = 1, PE = 2, PW = 3, PL = 4;
  localparam logic [1:0] K_HEAD = 2'd0, K_BODY = 2'd1, K_TAIL = 2'd2, K_SINGLE = 2'd3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic emu_en = 1'b1;
  logic [5*LW-1:0] link_i, link_o;
  logic [35:0] in_word [5];
  logic [1:0]  in_cr   [5];
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  for (genvar p = 0; p < 5; p++) begin : g_drv
    assign link_i[p*LW +: LW] = {in_cr[p], in_word[p]};
  end

  mesh_vc_router u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .emu_en_i (emu_en),
    .pos_x_i  (3'd3),
    .pos_y_i  (3'd3),
    .link_i   (link_i),
    .link_o   (link_o)
  );

  function automatic logic [37:0] lo(int p);
    return link_o[p*LW +: LW];
  endfunction

  function automatic logic [31:0] dst(int tag, int x, int y);
    return 32'((tag << 8) | (y << 3) | x);
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clr();
    for (int p = 0; p < 5; p++) begin
      in_word[p] = '0;
      in_cr[p]   = '0;
    end
  endtask

  task automatic put(int p, int vc, logic [1:0] kind, logic [31:0] pl);
    in_word[p] = {vc[0], kind, 1'b1, pl};
  endtask

  task automatic do_reset();
    clr();
    emu_en = 1'b1;
    rst_ni = 1'b0;
    tick();
    tick();
    rst_ni = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    for (int p = 0; p < 5; p++) begin
      chk("R1", "valid after reset", lo(p)[32], 1'b0);
      chk("R1", "credits after reset", lo(p)[37:36], 2'b00);
    end
  endtask

  task automatic t_route(int x, int y, int exp_p, int vc);
    int nv;
    do_reset();
    put(PL, vc, K_SINGLE, dst(8'h5A, x, y));
    tick();
    clr();
    chk("R9", "output too early", lo(exp_p)[32], 1'b0);
    tick();
    chk("R3", "route port valid", lo(exp_p)[32], 1'b1);
    chk("R3", "route payload", lo(exp_p)[31:0], dst(8'h5A, x, y));
    chk("R6", "credit return bit", lo(PL)[36 + vc], 1'b1);
    nv = 0;
    for (int p = 0; p < 5; p++) nv += int'(lo(p)[32]);
    chk("R3", "single output port", nv, 1);
  endtask

  task automatic t_wormhole();
    do_reset();
    put(PL, 0, K_HEAD, dst(1, 6, 3));
    tick();
    put(PL, 0, K_BODY, 32'h1111);
    tick();
    chk("R4", "head valid", lo(PE)[32], 1'b1);
    chk("R2", "head kind", lo(PE)[34:33], K_HEAD);
    chk("R2", "head vc", lo(PE)[35], 1'b0);
    chk("R4", "head payload", lo(PE)[31:0], dst(1, 6, 3));
    put(PL, 0, K_TAIL, 32'h2222);
    tick();
    chk("R2", "body kind", lo(PE)[34:33], K_BODY);
    chk("R4", "body payload", lo(PE)[31:0], 32'h1111);
    clr();
    tick();
    chk("R2", "tail kind", lo(PE)[34:33], K_TAIL);
    chk("R4", "tail vc", lo(PE)[35], 1'b0);
    chk("R4", "tail payload", lo(PE)[31:0], 32'h2222);
    tick();
    chk("R4", "idle after tail", lo(PE)[32], 1'b0);
  endtask

  task automatic t_hold();
    do_reset();
    put(PW, 0, K_HEAD, dst(8'hA, 6, 3));
    tick();
    clr();
    put(PS, 0, K_HEAD, dst(8'hB, 7, 1));
    tick();
    chk("R4", "first head vc0", {lo(PE)[32], lo(PE)[35]}, 2'b10);
    clr();
    put(PN, 0, K_HEAD, dst(8'hC, 4, 5));
    tick();
    chk("R4", "second head vc1", {lo(PE)[32], lo(PE)[35]}, 2'b11);
    chk("R4", "second head payload", lo(PE)[31:0], dst(8'hB, 7, 1));
    clr();
    tick();
    chk("R4", "third head blocked a", lo(PE)[32], 1'b0);
    put(PW, 0, K_TAIL, 32'hAAAA);
    tick();
    chk("R4", "third head blocked b", lo(PE)[32], 1'b0);
    clr();
    tick();
    chk("R4", "tail frees vc0", {lo(PE)[32], lo(PE)[35], lo(PE)[34:33]}, {2'b10, K_TAIL});
    tick();
    chk("R4", "third head after release", {lo(PE)[32], lo(PE)[35]}, 2'b10);
    chk("R4", "third head payload", lo(PE)[31:0], dst(8'hC, 4, 5));
  endtask

  task automatic t_rr();
    int cnt, last, repeats;
    do_reset();
    cnt = 0; last = -1; repeats = 0;
    for (int i = 0; i < 9; i++) begin
      clr();
      if (i < 3) begin
        put(PW, 0, K_SINGLE, dst(8'hA0 + i, 6, 3));
        put(PS, 0, K_SINGLE, dst(8'hB0 + i, 5, 2));
      end
      tick();
      if (lo(PE)[32]) begin
        cnt++;
        if (int'(lo(PE)[15:12]) == last) repeats++;
        last = int'(lo(PE)[15:12]);
      end
    end
    clr();
    chk("R7", "flits delivered", cnt, 6);
    chk("R7", "same source twice in a row", repeats, 0);
  endtask

  task automatic t_credit();
    int cnt;
    do_reset();
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      clr();
      if (i < 16) put(PW, i % 2, K_SINGLE, dst(i, 6, 3));
      tick();
      cnt += int'(lo(PE)[32]);
    end
    chk("R5", "flits sent on 16 credits", cnt, 16);
    cnt = 0;
    for (int i = 0; i < 11; i++) begin
      clr();
      if (i < 8) put(PW, 0, K_SINGLE, dst(8'h40 + i, 6, 3));
      tick();
      cnt += int'(lo(PE)[32]);
    end
    chk("R5", "flits sent with no credit", cnt, 0);
    for (int i = 0; i < 8; i++) begin
      clr();
      in_cr[PE] = 2'b10;
      tick();
      clr();
      tick();
      chk("R10", "buffered flit valid", {lo(PE)[32], lo(PE)[35]}, 2'b11);
      chk("R10", "buffered flit order", lo(PE)[31:0], dst(8'h40 + i, 6, 3));
    end
  endtask

  task automatic t_gate();
    int nv;
    do_reset();
    emu_en = 1'b0;
    put(PL, 0, K_SINGLE, dst(1, 5, 3));
    tick(); tick(); tick();
    clr();
    emu_en = 1'b1;
    tick(); tick();
    nv = 0;
    for (int p = 0; p < 5; p++) nv += int'(lo(p)[32]);
    chk("R8", "input ignored while disabled", nv, 0);
    put(PL, 0, K_SINGLE, dst(2, 5, 3));
    tick();
    clr();
    emu_en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R8", "frozen while disabled", lo(PE)[32], 1'b0);
    end
    emu_en = 1'b1;
    tick();
    chk("R8", "resumes after enable", lo(PE)[32], 1'b1);
    chk("R8", "resumed payload", lo(PE)[31:0], dst(2, 5, 3));
  endtask

  initial begin
    clr();
    t_reset();
    t_route(5, 5, PE, 0);
    t_route(1, 0, PW, 1);
    t_route(3, 6, PN, 0);
    t_route(3, 0, PS, 1);
    t_route(3, 3, PL, 0);
    t_wormhole();
    t_hold();
    t_rr();
    t_credit();
    t_gate();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule